// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Full and Half-Full Flags

This block buffers 9-bit words between two unrelated clock domains. A producer pushes words on the write clock while holding the active-low write enable low. A consumer pulls words on the read clock with an active-low read enable. The storage depth D is a power-of-two parameter, kept small by default. Both pointers pass between the domains as Gray codes through two-flop synchronizers. One asynchronous reset, active low, clears both sides.

All occupancy flags are active low and computed in the write domain. The occupancy is the write pointer minus the synchronized read pointer. The almost-full flag compares this count with D minus a programmable offset m. The offset sits in a write-domain register that loads in parallel and resets to a parameter default. The half-full flag shows when more than D/2 words are stored.

A parameter selects the read behaviour:
- **Standard mode:** each read request copies the next word into the output register.
- **Fall-through mode:** the oldest word moves into the output register on its own. A read consumes that word, and the register refills from memory. The word held in the output register has already left memory, so it is not counted in the occupancy that drives the flags.

Top module: `pflag_fifo`

## Requirements
- R1: After reset, full_n, paf_n and hf_n are 1, empty_n is 0 and the almost-full offset equals the OFS_DEFAULT parameter.
- R2: Words leave the FIFO in the order in which they were written, with no loss and no duplication.
- R3: In standard mode, dout changes only on a rising rclk edge where ren_n is 0 and the FIFO holds data. It then shows the oldest word after that edge. empty_n is 1 while memory holds any word.
- R4: In fall-through mode, the oldest word appears on dout without a read request, and empty_n is 1 while dout holds a valid word. A read with ren_n = 0 consumes that word, and the output register refills from memory when a word is available.
- R5: full_n is 0 while the write-domain count equals D. A write attempted while full_n is 0 changes neither memory nor the pointers.
- R6: A read attempted while the FIFO is empty changes neither dout nor the read pointer, and later traffic is delivered intact.
- R7: paf_n is 0 exactly when the write-domain count is at least D - m. After a read, paf_n can rise only on a later wclk edge, once the read pointer has crossed the synchronizer, never at the read edge itself.
- R8: hf_n is 0 exactly when the write-domain count is at least D/2 + 1. It rises when reads bring the count back to D/2.
- R9: In fall-through mode, the word held in the output register is excluded from the count behind full_n, paf_n and hf_n.
- R10: A rising wclk edge with ofs_ld_n = 0 loads ofs_in (range 0 to D-1) into the offset m. paf_n then follows the new threshold D - m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| wen_n | input | 1 | Write enable, active low |
| din | input | DATA_W (9) | Write data |
| ofs_ld_n | input | 1 | Offset load strobe, active low, wclk domain |
| ofs_in | input | ADDR_W (4) | New almost-full offset m |
| ren_n | input | 1 | Read enable, active low |
| dout | output | DATA_W (9) | Output register |
| empty_n | output | 1 | 0 when no word is available to read |
| full_n | output | 1 | Full flag, active low |
| paf_n | output | 1 | Programmable almost-full flag, active low |
| hf_n | output | 1 | Half-full flag, active low |

## Verification
Two things can fall in the same window:
- **Almost-full release against the read that frees space.** The bench issues a read on a standard-mode FIFO sitting exactly at the threshold. It samples paf_n at the next read-clock falling edge and expects it still asserted. After several write clocks it expects paf_n released.
- **Fall-through against memory fill.** Both modes receive the same write stream. While the flags are updating, the fall-through instance moves its first word into the output register. The bench expects that instance to show one fewer stored word: paf_n stays high at the count where the standard instance asserts it.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;
   typedef enum logic {
      RD_STANDARD = 1'b0,
      RD_FALLTHRU = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/pff_sync2.sv
module pff_sync2 #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/pff_mem.sv
module pff_mem #(
   parameter int AW = 4,
   parameter int DW = 9
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/pff_wr_side.sv
module pff_wr_side #(
   parameter int AW          = 4,
   parameter int OFS_DEFAULT = 2
) (
   input  logic          wclk,
   input  logic          rst_n,
   input  logic          wen_n,
   input  logic          ofs_ld_n,
   input  logic [AW-1:0] ofs_in,
   input  logic [AW:0]   rgray_sync,
   output logic          mem_we,
   output logic [AW-1:0] waddr,
   output logic [AW:0]   wbin,
   output logic [AW:0]   wgray,
   output logic          full_n,
   output logic          paf_n,
   output logic          hf_n
);
   localparam int PW = AW + 1;
   localparam logic [AW:0] DEPTH_V = PW'(1 << AW);
   localparam logic [AW:0] HALF_V  = PW'(1 << (AW - 1));

   logic [AW-1:0] ofs_q;
   logic [AW:0]   rbin_sync;
   logic [AW:0]   level;
   logic [AW:0]   paf_thr;

   always_comb begin
      rbin_sync[AW] = rgray_sync[AW];
      for (int i = AW - 1; i >= 0; i--) begin
         rbin_sync[i] = rbin_sync[i+1] ^ rgray_sync[i];
      end
   end

   assign level   = wbin - rbin_sync;
   assign paf_thr = DEPTH_V - {1'b0, ofs_q};
   assign full_n  = (level != DEPTH_V);
   assign paf_n   = !(level >= paf_thr);
   assign hf_n    = !(level > HALF_V);
   assign mem_we  = !wen_n && full_n;
   assign waddr   = wbin[AW-1:0];

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (mem_we) begin
         wbin  <= wbin + 1'b1;
         wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      end
   end

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n)         ofs_q <= AW'(OFS_DEFAULT);
      else if (!ofs_ld_n) ofs_q <= ofs_in;
   end
endmodule

// File: rtl/pff_rd_side.sv
module pff_rd_side
   import pflag_fifo_pkg::*;
#(
   parameter int       AW   = 4,
   parameter int       DW   = 9,
   parameter rd_mode_e MODE = RD_STANDARD
) (
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          ren_n,
   input  logic [AW:0]   wgray_sync,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rbin,
   output logic [AW:0]   rgray,
   output logic          mem_empty,
   output logic [DW-1:0] dout,
   output logic          empty_n
);
   logic rd_adv;

   assign mem_empty = (rgray == wgray_sync);
   assign raddr     = rbin[AW-1:0];

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rd_adv) begin
         rbin  <= rbin + 1'b1;
         rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
      end
   end

   generate
      if (MODE == RD_FALLTHRU) begin : g_fallthru
         logic held;
         logic take;
         assign take    = !ren_n && held;
         assign rd_adv  = !mem_empty && (!held || take);
         assign empty_n = held;
         always_ff @(posedge rclk or negedge rst_n) begin
            if (!rst_n) begin
               held <= 1'b0;
               dout <= '0;
            end else if (rd_adv) begin
               held <= 1'b1;
               dout <= mem_rdata;
            end else if (take) begin
               held <= 1'b0;
            end
         end
      end else begin : g_standard
         assign rd_adv  = !ren_n && !mem_empty;
         assign empty_n = !mem_empty;
         always_ff @(posedge rclk or negedge rst_n) begin
            if (!rst_n)      dout <= '0;
            else if (rd_adv) dout <= mem_rdata;
         end
      end
   endgenerate
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
   import pflag_fifo_pkg::*;
#(
   parameter int       DATA_W      = 9,
   parameter int       ADDR_W      = 4,
   parameter int       OFS_DEFAULT = 2,
   parameter rd_mode_e MODE        = RD_STANDARD
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              wen_n,
   input  logic [DATA_W-1:0] din,
   input  logic              ofs_ld_n,
   input  logic [ADDR_W-1:0] ofs_in,
   input  logic              ren_n,
   output logic [DATA_W-1:0] dout,
   output logic              empty_n,
   output logic              full_n,
   output logic              paf_n,
   output logic              hf_n
);
   localparam int PW    = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;

   initial begin
      assert (DATA_W >= 1) else $error("pflag_fifo: DATA_W must be positive");
      assert (ADDR_W >= 2 && ADDR_W <= 12) else $error("pflag_fifo: ADDR_W out of range");
      assert (OFS_DEFAULT >= 0 && OFS_DEFAULT < DEPTH)
         else $error("pflag_fifo: OFS_DEFAULT must lie in 0..DEPTH-1");
   end

   logic              mem_we;
   logic [ADDR_W-1:0] waddr;
   logic [ADDR_W-1:0] raddr;
   logic [DATA_W-1:0] mem_rdata;
   logic [PW-1:0]     wr_ptr;
   logic [PW-1:0]     wgray;
   logic [PW-1:0]     wgray_sync;
   logic [PW-1:0]     rd_ptr;
   logic [PW-1:0]     rgray;
   logic [PW-1:0]     rgray_sync;
   logic              rd_mem_empty;

   pff_wr_side #(.AW(ADDR_W), .OFS_DEFAULT(OFS_DEFAULT)) wr_i (
      .wclk(wclk), .rst_n(rst_n), .wen_n(wen_n), .ofs_ld_n(ofs_ld_n),
      .ofs_in(ofs_in), .rgray_sync(rgray_sync), .mem_we(mem_we),
      .waddr(waddr), .wbin(wr_ptr), .wgray(wgray), .full_n(full_n),
      .paf_n(paf_n), .hf_n(hf_n)
   );

   pff_mem #(.AW(ADDR_W), .DW(DATA_W)) mem_i (
      .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(din),
      .raddr(raddr), .rdata(mem_rdata)
   );

   pff_sync2 #(.W(PW)) r2w_i (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_sync));
   pff_sync2 #(.W(PW)) w2r_i (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_sync));

   pff_rd_side #(.AW(ADDR_W), .DW(DATA_W), .MODE(MODE)) rd_i (
      .rclk(rclk), .rst_n(rst_n), .ren_n(ren_n), .wgray_sync(wgray_sync),
      .mem_rdata(mem_rdata), .raddr(raddr), .rbin(rd_ptr), .rgray(rgray),
      .mem_empty(rd_mem_empty), .dout(dout), .empty_n(empty_n)
   );
endmodule

// File: rtl/pflag_fifo_chk.sv
module pflag_fifo_chk #(
   parameter int AW = 4
) (
   input logic        wclk,
   input logic        rclk,
   input logic        rst_n,
   input logic        wen_n,
   input logic        ren_n,
   input logic        ofs_ld_n,
   input logic        full_n,
   input logic        paf_n,
   input logic        hf_n,
   input logic [AW:0] wr_ptr,
   input logic [AW:0] rd_ptr,
   input logic        rd_mem_empty
);
   // R5
   no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      (!full_n && !wen_n) |=> $stable(wr_ptr));

   // R6
   no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
      rd_mem_empty |=> $stable(rd_ptr));

   // R7
   full_implies_paf_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      !full_n |-> !paf_n);

   // R8
   full_implies_hf_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      !full_n |-> !hf_n);

   // R7
   paf_set_cause_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      $fell(paf_n) |-> $past(!wen_n || !ofs_ld_n));

   // R8
   hf_set_cause_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      $fell(hf_n) |-> $past(!wen_n));

   // R5
   wr_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      wen_n |=> $stable(wr_ptr));
endmodule

bind pflag_fifo pflag_fifo_chk #(.AW(ADDR_W)) chk_i (
   .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen_n(wen_n), .ren_n(ren_n),
   .ofs_ld_n(ofs_ld_n), .full_n(full_n), .paf_n(paf_n), .hf_n(hf_n),
   .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rd_mem_empty(rd_mem_empty)
);

// File: tb/pflag_fifo_tb_top.sv
module pflag_fifo_tb_top;
   import pflag_fifo_pkg::*;

   localparam int DW = 9;
   localparam int AW = 4;
   localparam int D  = 1 << AW;

   logic wclk = 1'b0;
   logic rclk = 1'b0;
   logic rst_n = 1'b0;
   logic wen_n = 1'b1;
   logic [DW-1:0] din = '0;
   logic ofs_ld_n = 1'b1;
   logic [AW-1:0] ofs_in = '0;
   logic ren_s_n = 1'b1;
   logic ren_f_n = 1'b1;
   logic [DW-1:0] dout_s, dout_f;
   logic empty_s_n, full_s_n, paf_s_n, hf_s_n;
   logic empty_f_n, full_f_n, paf_f_n, hf_f_n;

   int n_chk = 0;
   int n_bad = 0;

   always #5 wclk = ~wclk;
   always #7 rclk = ~rclk;

   pflag_fifo #(.DATA_W(DW), .ADDR_W(AW), .OFS_DEFAULT(2), .MODE(RD_STANDARD)) dut_i (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen_n(wen_n), .din(din),
      .ofs_ld_n(ofs_ld_n), .ofs_in(ofs_in), .ren_n(ren_s_n), .dout(dout_s),
      .empty_n(empty_s_n), .full_n(full_s_n), .paf_n(paf_s_n), .hf_n(hf_s_n)
   );

   pflag_fifo #(.DATA_W(DW), .ADDR_W(AW), .OFS_DEFAULT(2), .MODE(RD_FALLTHRU)) dut_fwft_i (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen_n(wen_n), .din(din),
      .ofs_ld_n(ofs_ld_n), .ofs_in(ofs_in), .ren_n(ren_f_n), .dout(dout_f),
      .empty_n(empty_f_n), .full_n(full_f_n), .paf_n(paf_f_n), .hf_n(hf_f_n)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic push(input logic [DW-1:0] v);
      @(negedge wclk); wen_n = 1'b0; din = v;
      @(negedge wclk); wen_n = 1'b1;
   endtask

   task automatic settle();
      repeat (6) @(negedge wclk);
      repeat (2) @(negedge rclk);
   endtask

   task automatic pop_std();
      @(negedge rclk); ren_s_n = 1'b0;
      @(negedge rclk); ren_s_n = 1'b1;
   endtask

   task automatic pop_fwft();
      @(negedge rclk); ren_f_n = 1'b0;
      @(negedge rclk); ren_f_n = 1'b1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge wclk);
      rst_n = 1'b1;
      repeat (2) @(negedge wclk);
   endtask

   task automatic t_reset_state();
      chk("R1 full_n",  16'(full_s_n), 16'd1);
      chk("R1 paf_n",   16'(paf_s_n),  16'd1);
      chk("R1 hf_n",    16'(hf_s_n),   16'd1);
      chk("R1 empty_n", 16'(empty_s_n), 16'd0);
      chk("R1 fwft empty_n", 16'(empty_f_n), 16'd0);
   endtask

   task automatic t_fill();
      for (int i = 0; i < D; i++) begin
         push(DW'(9'h0A0 + i));
         if (i + 1 == D/2)     chk("R8 hf_n at D/2", 16'(hf_s_n), 16'd1);
         if (i + 1 == D/2 + 1) chk("R8 hf_n at D/2+1", 16'(hf_s_n), 16'd0);
         if (i + 1 == D - 3)   chk("R7 paf_n at D-m-1", 16'(paf_s_n), 16'd1);
         if (i + 1 == D - 2) begin
            chk("R7 paf_n at D-m", 16'(paf_s_n), 16'd0);
            settle();
            chk("R9 fwft paf_n excludes output word", 16'(paf_f_n), 16'd1);
            chk("R4 fwft dout without read", 16'(dout_f), 16'h0A0);
            chk("R3 std dout untouched", 16'(dout_s), 16'h000);
         end
         if (i + 1 == D - 1) chk("R9 fwft paf_n at D-m in memory", 16'(paf_f_n), 16'd0);
      end
      chk("R5 std full_n at D", 16'(full_s_n), 16'd0);
      chk("R9 fwft full_n one short", 16'(full_f_n), 16'd1);
      push(9'h1FF);
      chk("R5 fwft full_n", 16'(full_f_n), 16'd0);
      push(9'h155);
      settle();
   endtask

   task automatic t_drain_std();
      for (int i = 1; i <= D; i++) begin
         pop_std();
         chk("R2 std order", 16'(dout_s), 16'(9'h0A0 + i - 1));
         if (i == 3) chk("R7 paf_n held at read edge", 16'(paf_s_n), 16'd0);
         settle();
         chk("R7 paf_n level", 16'(paf_s_n), ((D - i) >= D - 2) ? 16'd0 : 16'd1);
         chk("R8 hf_n level",  16'(hf_s_n),  ((D - i) >= D/2 + 1) ? 16'd0 : 16'd1);
         if (i == 1) chk("R5 full_n released", 16'(full_s_n), 16'd1);
      end
      chk("R3 std empty_n", 16'(empty_s_n), 16'd0);
   endtask

   task automatic t_drain_fwft();
      for (int i = 0; i <= D; i++) begin
         chk("R4 fwft empty_n", 16'(empty_f_n), 16'd1);
         chk("R2 fwft order", 16'(dout_f), (i == D) ? 16'h1FF : 16'(9'h0A0 + i));
         pop_fwft();
         repeat (4) @(negedge rclk);
      end
      chk("R4 fwft empty after drain", 16'(empty_f_n), 16'd0);
   endtask

   task automatic t_empty_reads();
      pop_std();
      pop_fwft();
      chk("R6 std dout kept", 16'(dout_s), 16'h0AF);
      chk("R6 fwft empty kept", 16'(empty_f_n), 16'd0);
      push(9'h033);
      settle();
      chk("R3 std dout before read", 16'(dout_s), 16'h0AF);
      chk("R3 std empty_n", 16'(empty_s_n), 16'd1);
      pop_std();
      chk("R6 std after empty read", 16'(dout_s), 16'h033);
      chk("R6 fwft after empty read", 16'(dout_f), 16'h033);
   endtask

   task automatic t_offset();
      do_reset();
      t_reset_state();
      @(negedge wclk); ofs_ld_n = 1'b0; ofs_in = 4'd5;
      @(negedge wclk); ofs_ld_n = 1'b1;
      for (int i = 1; i <= 11; i++) begin
         push(DW'(i));
         if (i == 10) chk("R10 paf_n below D-5", 16'(paf_s_n), 16'd1);
         if (i == 11) chk("R10 paf_n at D-5", 16'(paf_s_n), 16'd0);
      end
      @(negedge wclk); ofs_ld_n = 1'b0; ofs_in = 4'd1;
      @(negedge wclk); ofs_ld_n = 1'b1;
      chk("R10 paf_n after offset 1", 16'(paf_s_n), 16'd1);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      do_reset();
      t_reset_state();
      t_fill();
      t_drain_std();
      t_drain_fwft();
      t_empty_reads();
      t_offset();
      finish_run();
   end
endmodule